// File: doc/BRIEF.md
# Translated index bit predictor

A physically indexed cache needs two index bits that are themselves produced by address translation. Waiting for those bits would add the full translation delay to every cache read. This block guesses the two bits early so that the cache read can start at once. The guess comes from a small history table, and the table is keyed by the contents of the register that forms the operand address, not by the address itself.

In the address-add cycle the block picks the base register value when a base is given, and otherwise the index register value. It takes an 8-bit field of that value and reads the table entry at that position. At the clock edge that starts the cache access cycle, the entry is captured and driven out as the predicted bits. In that same cycle the translation unit returns the real bits from the matching translation entry, and the block compares them with the guess. When they differ, the block raises hit-suppress so that the data read with the wrong bits is discarded. It also raises recycle so that the request is replayed with the correct bits, and it writes the correct bits into the table entry the request used. Each mispredicted request costs one replay pass of the cache.

Top module: `xlat_bit_predictor`

## Requirements
- R1: During and right after reset, `pred_bits` is 0 and `hit_suppress` and `recycle` are low. Every table entry predicts 0 until it is first written.
- R2: The table index is the 8-bit field made of bits 12 to 19 of a 32-bit register value, with bits numbered from 0 at the MSB. This field is `value[19:12]` in LSB-0 numbering, and big-endian bit 12 is the index MSB. The base value is used when `base_valid` is high; otherwise the index value is used when `index_valid` is high; otherwise entry 0 is read.
- R3: A lookup requested with `req_valid` in cycle N drives the entry's contents on `pred_bits` in cycle N+1.
- R4: In the cycle after a request, if `act_valid` is high and `act_bits` differs from `pred_bits`, then `hit_suppress` and `recycle` are both high in that same cycle.
- R5: `hit_suppress` and `recycle` stay low when the bits match, when `act_valid` is low, or when there was no request in the cycle before.
- R6: After a mismatch, the entry used by the request takes the value of `act_bits`. A lookup in the cycle after the mismatch already sees the new value. A lookup in the mismatch cycle itself sees the old value.
- R7: A correction changes only the entry used by the mispredicted request; all other entries keep their values.
- R8: In a cycle that follows one with no request, `pred_bits` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request in its address-add cycle |
| base_valid | input | 1 | A base register is specified |
| base_value | input | 32 | Base register contents |
| index_valid | input | 1 | An index register is specified |
| index_value | input | 32 | Index register contents |
| act_valid | input | 1 | Translated bits are available (cache access cycle) |
| act_bits | input | 2 | Translated index bits from the matching translation entry |
| pred_bits | output | 2 | Predicted index bits for the cache access cycle |
| hit_suppress | output | 1 | Discard the cache hit of this cycle |
| recycle | output | 1 | Replay the request with the translated bits |

## Verification
A corrupted or stale table entry appears at the ports one cycle after a lookup of that entry: `pred_bits` shows the wrong value, and if the translated bits arrive in that cycle, `hit_suppress` and `recycle` take the wrong level in that same cycle. A lost or misdirected correction appears only when the entry is next looked up. For this reason the stimulus reuses a small pool of register values and issues back-to-back requests to the same entry, so that the forwarding of a fresh correction is exercised at once. A wrong index field or a wrong choice of register appears as a prediction taken from an entry whose contents differ from those of the intended entry.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  // Where the lookup register came from
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_INDEX = 2'd1,
    SRC_BASE  = 2'd2
  } xbp_src_e;

  // Map a big-endian (bit 0 = MSB) bit position to LSB-0 numbering.
  function automatic int unsigned be_to_lsb(input int unsigned be_pos,
                                            input int unsigned width);
    return width - 1 - be_pos;
  endfunction

  // LSB-0 position of the least significant bit of a big-endian field.
  function automatic int unsigned field_lsb(input int unsigned be_first,
                                            input int unsigned len,
                                            input int unsigned width);
    return be_to_lsb(be_first + len - 1, width);
  endfunction
endpackage

// File: rtl/xbp_index_select.sv
module xbp_index_select
  import xbp_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned FIELD_BE_LO = 12
) (
  input  logic             base_valid,
  input  logic [REG_W-1:0] base_value,
  input  logic             index_valid,
  input  logic [REG_W-1:0] index_value,
  output logic [IDX_W-1:0] look_idx
);
  localparam int unsigned FLSB = field_lsb(FIELD_BE_LO, IDX_W, REG_W);

  xbp_src_e src;
  logic     unused_reg_bits;

  // Base wins, then index, then entry 0
  always_comb begin
    if (base_valid)       src = SRC_BASE;
    else if (index_valid) src = SRC_INDEX;
    else                  src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_BASE:  look_idx = base_value[FLSB +: IDX_W];
      SRC_INDEX: look_idx = index_value[FLSB +: IDX_W];
      default:   look_idx = '0;
    endcase
  end

  assign unused_reg_bits = ^{base_value, index_value};
endmodule

// File: rtl/xbp_history_table.sv
module xbp_history_table #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PRED_W  = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PRED_W-1:0] rd_bits,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PRED_W-1:0] wr_bits
);
  logic [PRED_W-1:0] slot [ENTRIES];
  logic              fwd_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot[e] <= '0;
      else if (wr_en && (wr_idx == SLOT_ID)) slot[e] <= wr_bits;
    end
  end

  // A write in flight wins over the stored value for the same entry
  assign fwd_hit = wr_en && (wr_idx == rd_idx);
  assign rd_bits = fwd_hit ? wr_bits : slot[rd_idx];
endmodule

// File: rtl/xbp_verify.sv
module xbp_verify #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned PRED_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [PRED_W-1:0] look_bits,
  input  logic              act_valid,
  input  logic [PRED_W-1:0] act_bits,
  output logic [PRED_W-1:0] pred_bits,
  output logic              stage_live,
  output logic              mispredict,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [PRED_W-1:0] upd_bits
);
  logic [IDX_W-1:0] stage_idx;

  // Capture at the start of the cache access cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_live <= 1'b0;
      pred_bits  <= '0;
      stage_idx  <= '0;
    end else begin
      stage_live <= req_valid;
      if (req_valid) begin
        pred_bits <= look_bits;
        stage_idx <= look_idx;
      end
    end
  end

  assign mispredict = stage_live && act_valid && (act_bits != pred_bits);

  // Correction is committed one cycle after the mismatch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_en   <= 1'b0;
      upd_idx  <= '0;
      upd_bits <= '0;
    end else begin
      upd_en <= mispredict;
      if (mispredict) begin
        upd_idx  <= stage_idx;
        upd_bits <= act_bits;
      end
    end
  end
endmodule

// File: rtl/xlat_bit_predictor.sv
module xlat_bit_predictor #(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned ENTRIES     = 256,
  parameter int unsigned PRED_W      = 2,
  parameter int unsigned FIELD_BE_LO = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              base_valid,
  input  logic [REG_W-1:0]  base_value,
  input  logic              index_valid,
  input  logic [REG_W-1:0]  index_value,
  input  logic              act_valid,
  input  logic [PRED_W-1:0] act_bits,
  output logic [PRED_W-1:0] pred_bits,
  output logic              hit_suppress,
  output logic              recycle
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // Named internal events, visible to the bound checker
  logic [IDX_W-1:0]  look_idx;
  logic [PRED_W-1:0] look_bits;
  logic              stage_live;
  logic              mispredict;
  logic              upd_en;
  logic [IDX_W-1:0]  upd_idx;
  logic [PRED_W-1:0] upd_bits;

  xbp_index_select #(
    .REG_W(REG_W), .IDX_W(IDX_W), .FIELD_BE_LO(FIELD_BE_LO)
  ) u_sel (
    .base_valid (base_valid),
    .base_value (base_value),
    .index_valid(index_valid),
    .index_value(index_value),
    .look_idx   (look_idx)
  );

  xbp_history_table #(
    .ENTRIES(ENTRIES), .PRED_W(PRED_W)
  ) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (look_idx),
    .rd_bits(look_bits),
    .wr_en  (upd_en),
    .wr_idx (upd_idx),
    .wr_bits(upd_bits)
  );

  xbp_verify #(
    .IDX_W(IDX_W), .PRED_W(PRED_W)
  ) u_vfy (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .look_idx  (look_idx),
    .look_bits (look_bits),
    .act_valid (act_valid),
    .act_bits  (act_bits),
    .pred_bits (pred_bits),
    .stage_live(stage_live),
    .mispredict(mispredict),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_bits  (upd_bits)
  );

  assign hit_suppress = mispredict;
  assign recycle      = mispredict;
endmodule

// File: rtl/xbp_checker.sv
module xbp_checker #(
  parameter int unsigned PRED_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              act_valid,
  input logic [PRED_W-1:0] act_bits,
  input logic [PRED_W-1:0] pred_bits,
  input logic              hit_suppress,
  input logic              recycle,
  input logic              upd_en,
  input logic [PRED_W-1:0] upd_bits
);
  // R1: clean outputs on the first edge out of reset
  assert_reset_clean_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pred_bits == '0) && !hit_suppress && !recycle);

  // R4: a differing translation after a request suppresses and recycles
  assert_mismatch_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req_valid) && act_valid && (act_bits != pred_bits)
      |-> hit_suppress && recycle);

  // R5: suppress only with a real, differing translation
  assert_suppress_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_suppress |-> act_valid && (act_bits != pred_bits));

  // R5: no recycle without a request in the previous cycle
  assert_recycle_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !recycle);

  // R6: the correction carries the translated bits one cycle later
  assert_correction_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recycle |=> upd_en && (upd_bits == $past(act_bits)));

  // R8: prediction holds without a request
  assert_pred_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(req_valid) |-> $stable(pred_bits));
endmodule

bind xlat_bit_predictor xbp_checker #(.PRED_W(PRED_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .act_valid   (act_valid),
  .act_bits    (act_bits),
  .pred_bits   (pred_bits),
  .hit_suppress(hit_suppress),
  .recycle     (recycle),
  .upd_en      (upd_en),
  .upd_bits    (upd_bits)
);

// File: tb/sim_xlat_bit_predictor.sv
`timescale 1ns/1ps
module sim_xlat_bit_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        base_valid = 1'b0;
  logic [31:0] base_value = '0;
  logic        index_valid = 1'b0;
  logic [31:0] index_value = '0;
  logic        act_valid = 1'b0;
  logic [1:0]  act_bits = '0;
  logic [1:0]  pred_bits;
  logic        hit_suppress;
  logic        recycle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [1:0] model [256];
  logic [1:0] exp_pred = '0;
  bit         prev_live = 1'b0;
  int         prev_idx = 0;

  always #2 clk = ~clk;

  xlat_bit_predictor u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .base_valid(base_valid), .base_value(base_value),
    .index_valid(index_valid), .index_value(index_value),
    .act_valid(act_valid), .act_bits(act_bits),
    .pred_bits(pred_bits), .hit_suppress(hit_suppress), .recycle(recycle)
  );

  // Index from big-endian bits 12..19, bit 12 being the index MSB
  function automatic int ref_idx(input logic [31:0] v);
    int r = 0;
    for (int j = 0; j < 8; j++) r = (r << 1) | int'(v[31 - (12 + j)]);
    return r;
  endfunction

  function automatic logic [31:0] put_idx(input int idx, input logic [31:0] noise);
    logic [31:0] v = noise;
    for (int j = 0; j < 8; j++) v[31 - (12 + j)] = idx[7 - j];
    return v;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_cycle(input bit rq, input bit bv, input logic [31:0] bval,
                          input bit iv, input logic [31:0] ival,
                          input bit av, input logic [1:0] ab, input string tag);
    int nidx;
    logic [1:0] npred;
    bit mis;
    @(negedge clk);
    req_valid = rq; base_valid = bv; base_value = bval;
    index_valid = iv; index_value = ival; act_valid = av; act_bits = ab;
    #1;
    mis = prev_live && av && (ab != exp_pred);
    chk(pred_bits, exp_pred, {tag, " pred_bits"});
    chk(hit_suppress, mis, mis ? "R4 hit_suppress" : "R5 hit_suppress");
    chk(recycle, mis, mis ? "R4 recycle" : "R5 recycle");
    nidx = bv ? ref_idx(bval) : (iv ? ref_idx(ival) : 0);
    npred = model[nidx];
    if (mis) model[prev_idx] = ab;
    if (rq) begin exp_pred = npred; prev_idx = nidx; end
    prev_live = rq;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) model[i] = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pred_bits, 0, "R1 pred_bits in reset");
    chk(hit_suppress, 0, "R1 hit_suppress in reset");
    chk(recycle, 0, "R1 recycle in reset");
    rst_n = 1'b1;
    do_cycle(0, 0, 0, 0, 0, 0, 0, "R1");
    // Lookup 0xA5 via base (index register points elsewhere)
    do_cycle(1, 1, put_idx(8'hA5, 32'hFFF0_0FFF), 1, put_idx(8'h5A, 0), 0, 0, "R1");
    // R1 entry reads 0; translation says 3 -> R4; same lookup in mismatch cycle
    do_cycle(1, 1, put_idx(8'hA5, 32'h1234_5678), 0, 0, 1, 2'd3, "R1");
    // R6: lookup in mismatch cycle saw old value; this lookup sees forwarded value
    do_cycle(1, 1, put_idx(8'hA5, 0), 0, 0, 1, 2'd3, "R6 old value");
    do_cycle(0, 0, 0, 0, 0, 1, 2'd3, "R6 forwarded value");
    // R2: base beats index
    do_cycle(1, 1, put_idx(8'hA5, 32'h0F0F_0F0F), 1, put_idx(8'h5A, 0), 0, 0, "R8");
    do_cycle(1, 0, put_idx(8'hA5, 0), 1, put_idx(8'hA4, 32'hF00F_0FFF), 0, 0, "R2 base chosen");
    // R7: neighbour entry untouched; R2 index chosen when no base
    do_cycle(1, 0, put_idx(8'hA5, 0), 0, put_idx(8'hA5, 0), 0, 0, "R7 neighbour entry");
    do_cycle(0, 0, 0, 0, 0, 0, 0, "R2 neither register -> entry 0");
    do_cycle(0, 0, 0, 0, 0, 0, 0, "R8 hold");
    do_cycle(0, 0, 0, 0, 0, 1, 2'd1, "R8 hold");
    // Translation with no request: nothing happens (R5)
    do_cycle(1, 1, put_idx(8'hA5, 0), 0, 0, 1, 2'd2, "R5");
    do_cycle(0, 0, 0, 0, 0, 0, 2'd1, "R3 entry A5");
    do_cycle(0, 0, 0, 0, 0, 0, 0, "R8 hold after act_valid low");

    // Random phase over a small pool of entries
    for (int n = 0; n < 4000; n++) begin
      bit rq = ($urandom % 4) != 0;
      bit bv = $urandom % 2;
      bit iv = $urandom % 2;
      int ei = $urandom % 6;
      logic [31:0] bval = put_idx(ei * 37, $urandom);
      logic [31:0] ival = put_idx(($urandom % 6) * 37 + 1, $urandom);
      bit av = ($urandom % 8) != 0;
      logic [1:0] ab = (($urandom % 2) != 0) ? exp_pred : 2'($urandom);
      do_cycle(rq, bv, bval, iv, ival, av, ab, "R3");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule